// File: doc/BRIEF.md
# Dual-Compare Single-Pulse Output Generator

This block makes exactly one output pulse from a free-running up-counter and two compare values. The counter advances by one on each enabled clock. On the cycle after it equals the period value it returns to zero. Once the unit is armed, the first match against the primary compare value drives the output high. A later match against the secondary compare value drives it low again and sets a sticky interrupt flag. After that the unit ignores all further matches until it is armed again.

The two edges may fall in different counter periods, because the falling match is only looked for after the rising match has happened. Several corner cases have defined results:
- If the primary value is zero and the counter starts at zero, the first zero is skipped.
- If the secondary value is beyond the period, the output rises and never falls.
- If the primary value is beyond the period, nothing happens.

A compare value is only seen when the counter has reached it by counting. The value loaded at arm time never matches. The arm strobe can also preload the counter.

Top module: `oc_pulse_gen`

## Requirements
- R1: After reset the output and the flag are 0, the counter reads 0, and no pulse appears until the unit is armed.
- R2: While enabled and not armed, the counter advances by one per clock. The clock after it equals the period it reads 0. While the enable is low it holds its value.
- R3: An arm strobe loads the counter with the preload value and forces the output low on the next clock. It restarts the one-shot sequence and wins over counting in the same cycle.
- R4: After arming, the output goes high one clock after the counter, having reached the primary value by counting, shows that value.
- R5: After the rise, the output goes low one clock after the counter shows the secondary value reached by counting, and the flag is set on the same edge. Afterwards the output stays low until re-armed, so only one pulse is made.
- R6: If the secondary value is at or below the primary value, the fall happens in the counter period after the one that held the rise.
- R7: If the secondary value exceeds the period, the output rises and stays high, and the flag is never set.
- R8: If the primary value exceeds the period, the output stays low.
- R9: With a primary value of 0 and a preload of 0, no pulse comes during the first count up to the period; the rise follows the first wrap to zero. With a preload equal to the period, the rise follows at once after the first wrap.
- R10: With period, primary and secondary all 0 and the enable held high, the output is high for exactly one clock, the second clock after arming. The flag is set when the output falls.
- R11: The flag stays set until a clear strobe. If the clear arrives in the same cycle as the falling match, the flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Counter enable |
| arm | input | 1 | One-cycle strobe that preloads the counter and restarts the one-shot |
| period | input | W | Counter period value |
| cmp_rise | input | W | Primary compare value, sets the output high |
| cmp_fall | input | W | Secondary compare value, drives the output low |
| preload | input | W | Counter value loaded on arm |
| flag_clr | input | 1 | Flag clear strobe |
| pulse_out | output | 1 | Registered pulse output |
| flag | output | 1 | Sticky completion flag |
| timer_val | output | W | Current counter value |

## Verification
The falling compare, which sets the flag, can coincide with a clear strobe on the flag. The bench leaves the flag set from an earlier pulse and re-arms. It then drives the clear in exactly the cycle in which the counter shows the secondary value, and expects the flag still set afterwards. A clear on the next cycle must then drop it.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [1:0] {
    OC_IDLE,
    OC_WAIT_RISE,
    OC_WAIT_FALL,
    OC_DONE
  } oc_state_e;
endpackage

// File: rtl/oc_timer.sv
module oc_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         arm,
  input  logic [W-1:0] period,
  input  logic [W-1:0] preload,
  output logic [W-1:0] cnt,
  output logic         fresh
);
  // next counter value: wrap to zero after the period value
  function automatic logic [W-1:0] step_count(input logic [W-1:0] t, input logic [W-1:0] p);
    return (t == p) ? '0 : t + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      fresh <= 1'b0;
    end else if (arm) begin
      cnt   <= preload;
      fresh <= 1'b0;
    end else if (en) begin
      cnt   <= step_count(cnt, period);
      fresh <= 1'b1;
    end else begin
      fresh <= 1'b0;
    end
  end
endmodule

// File: rtl/oc_match.sv
module oc_match #(
  parameter int W = 16
) (
  input  logic         fresh,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp_rise,
  input  logic [W-1:0] cmp_fall,
  output logic         rise_hit,
  output logic         fall_hit
);
  // a compare only counts on a value the counter has just stepped to
  function automatic logic hit(input logic f, input logic [W-1:0] t, input logic [W-1:0] c);
    return f && (t == c);
  endfunction

  always_comb begin
    rise_hit = hit(fresh, cnt, cmp_rise);
    fall_hit = hit(fresh, cnt, cmp_fall);
  end
endmodule

// File: rtl/oc_fsm.sv
module oc_fsm
  import oc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      arm,
  input  logic      rise_hit,
  input  logic      fall_hit,
  input  logic      flag_clr,
  output oc_state_e state,
  output logic      rise_evt,
  output logic      fall_evt,
  output logic      pulse,
  output logic      flag
);
  always_comb begin
    rise_evt = !arm && (state == OC_WAIT_RISE) && rise_hit;
    fall_evt = !arm && (state == OC_WAIT_FALL) && fall_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= OC_IDLE;
      pulse <= 1'b0;
    end else if (arm) begin
      state <= OC_WAIT_RISE;
      pulse <= 1'b0;
    end else if (rise_evt) begin
      state <= OC_WAIT_FALL;
      pulse <= 1'b1;
    end else if (fall_evt) begin
      state <= OC_DONE;
      pulse <= 1'b0;
    end
  end

  // set has priority over clear
  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (fall_evt) flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end
endmodule

// File: rtl/oc_pulse_gen.sv
module oc_pulse_gen
  import oc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         arm,
  input  logic [W-1:0] period,
  input  logic [W-1:0] cmp_rise,
  input  logic [W-1:0] cmp_fall,
  input  logic [W-1:0] preload,
  input  logic         flag_clr,
  output logic         pulse_out,
  output logic         flag,
  output logic [W-1:0] timer_val
);
  logic [W-1:0] cnt;
  logic         fresh;
  logic         rise_hit;
  logic         fall_hit;
  logic         rise_evt;
  logic         fall_evt;
  oc_state_e    state;

  oc_timer #(.W(W)) u_timer (
    .clk(clk), .rst(rst), .en(en), .arm(arm),
    .period(period), .preload(preload),
    .cnt(cnt), .fresh(fresh)
  );

  oc_match #(.W(W)) u_match (
    .fresh(fresh), .cnt(cnt),
    .cmp_rise(cmp_rise), .cmp_fall(cmp_fall),
    .rise_hit(rise_hit), .fall_hit(fall_hit)
  );

  oc_fsm u_fsm (
    .clk(clk), .rst(rst), .arm(arm),
    .rise_hit(rise_hit), .fall_hit(fall_hit), .flag_clr(flag_clr),
    .state(state), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .pulse(pulse_out), .flag(flag)
  );

  assign timer_val = cnt;
endmodule

// File: rtl/oc_pulse_gen_chk.sv
module oc_pulse_gen_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         arm,
  input logic [W-1:0] period,
  input logic [W-1:0] preload,
  input logic         flag_clr,
  input logic         rise_evt,
  input logic         fall_evt,
  input logic         pulse_out,
  input logic         flag,
  input logic [W-1:0] timer_val
);
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (en && !arm && timer_val == period) |=> (timer_val == '0)); // R2
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    (!en && !arm) |=> $stable(timer_val)); // R2
  AST_ARM_LOAD: assert property (@(posedge clk) disable iff (rst)
    arm |=> (!pulse_out && timer_val == $past(preload))); // R3
  AST_RISE_HIGH: assert property (@(posedge clk) disable iff (rst)
    rise_evt |=> pulse_out); // R4
  AST_FALL_FLAG: assert property (@(posedge clk) disable iff (rst)
    fall_evt |=> (!pulse_out && flag)); // R5
  AST_NO_STRAY_RISE: assert property (@(posedge clk) disable iff (rst)
    (!pulse_out && !rise_evt) |=> !pulse_out); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag); // R11
endmodule

bind oc_pulse_gen oc_pulse_gen_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .arm(arm),
  .period(period), .preload(preload), .flag_clr(flag_clr),
  .rise_evt(rise_evt), .fall_evt(fall_evt),
  .pulse_out(pulse_out), .flag(flag), .timer_val(timer_val)
);

// File: tb/oc_pulse_gen_tb.sv
module oc_pulse_gen_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic         arm = 1'b0;
  logic [W-1:0] period = '0;
  logic [W-1:0] cmp_rise = '0;
  logic [W-1:0] cmp_fall = '0;
  logic [W-1:0] preload = '0;
  logic         flag_clr = 1'b0;
  logic         pulse_out;
  logic         flag;
  logic [W-1:0] timer_val;

  int n_chk = 0;
  int n_bad = 0;
  int k = 0;

  always #2.5 clk = ~clk;

  oc_pulse_gen #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .en(en), .arm(arm),
    .period(period), .cmp_rise(cmp_rise), .cmp_fall(cmp_fall),
    .preload(preload), .flag_clr(flag_clr),
    .pulse_out(pulse_out), .flag(flag), .timer_val(timer_val)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at k=%0d: actual %0d expected %0d", req, k, act, exp);
    end
  endtask

  task automatic chk_pulse(input string req, input int at_k, input bit exp);
    while (k < at_k) begin @(negedge clk); k++; end
    chk(pulse_out == exp, req, pulse_out, exp);
  endtask

  task automatic chk_flag(input string req, input bit exp);
    chk(flag == exp, req, flag, exp);
  endtask

  // arm at a falling edge; k=0 at the next falling edge
  task automatic do_arm(input int p, input int r, input int f, input int pl);
    @(negedge clk);
    period = W'(p); cmp_rise = W'(r); cmp_fall = W'(f); preload = W'(pl);
    en = 1'b1; arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    k = 0;
  endtask

  task automatic t_reset();
    chk(pulse_out == 1'b0, "R1 pulse", pulse_out, 0);
    chk(flag == 1'b0, "R1 flag", flag, 0);
    chk(timer_val == '0, "R1 timer", timer_val, 0);
    en = 1'b1;
    repeat (12) @(negedge clk);
    chk(pulse_out == 1'b0, "R1 no pulse unarmed", pulse_out, 0);
  endtask

  task automatic t_basic();
    do_arm(5, 2, 4, 0);
    chk(timer_val == 0, "R3 preload", timer_val, 0);
    chk_pulse("R4 low before rise", 2, 0);
    chk_pulse("R4 rise", 3, 1);
    chk_pulse("R5 still high", 4, 1);
    chk_pulse("R5 fall", 5, 0);
    chk_flag("R5 flag set", 1);
    chk(timer_val == 5, "R2 count", timer_val, 5);
    chk_pulse("R2 wrap", 6, 0);
    chk(timer_val == 0, "R2 wrap value", timer_val, 0);
    chk_pulse("R5 single pulse", 20, 0);
  endtask

  task automatic t_flag_race();
    // flag already set; clear coincides with falling match (interval k=4)
    do_arm(5, 2, 4, 0);
    chk_pulse("R11 setup", 4, 1);
    flag_clr = 1'b1;
    @(negedge clk); k++;
    flag_clr = 1'b1;
    chk(flag == 1'b1, "R11 set wins", flag, 1);
    @(negedge clk); k++;
    flag_clr = 1'b0;
    chk(flag == 1'b0, "R11 clear", flag, 0);
    repeat (3) @(negedge clk);
    chk(flag == 1'b0, "R11 stays clear", flag, 0);
  endtask

  task automatic t_wrap_fall();
    do_arm(5, 3, 1, 0);
    chk_pulse("R6 rise", 4, 1);
    chk_pulse("R6 high across wrap", 7, 1);
    chk_pulse("R6 fall next period", 8, 0);
    chk_flag("R6 flag", 1);
    flag_clr = 1'b1; @(negedge clk); k++; flag_clr = 1'b0;
  endtask

  task automatic t_fall_out_of_range();
    do_arm(5, 1, 7, 0);
    chk_pulse("R7 rise", 2, 1);
    chk_pulse("R7 stays high", 30, 1);
    chk_flag("R7 no flag", 0);
    do_arm(5, 1, 7, 0);
    chk(pulse_out == 1'b0, "R3 re-arm drops output", pulse_out, 0);
  endtask

  task automatic t_rise_out_of_range();
    do_arm(5, 6, 2, 0);
    for (int i = 1; i <= 30; i++) chk_pulse("R8 stays low", i, 0);
    chk_flag("R8 no flag", 0);
  endtask

  task automatic t_zero_rise();
    do_arm(5, 0, 2, 0);
    for (int i = 1; i <= 6; i++) chk_pulse("R9 first zero skipped", i, 0);
    chk_pulse("R9 rise after wrap", 7, 1);
    chk_pulse("R9 high", 8, 1);
    chk_pulse("R9 fall", 9, 0);
    flag_clr = 1'b1; @(negedge clk); k++; flag_clr = 1'b0;
    do_arm(5, 0, 2, 5);
    chk_pulse("R9 preload period no rise yet", 1, 0);
    chk_pulse("R9 preload period rise", 2, 1);
    chk_pulse("R9 preload period fall", 4, 0);
    flag_clr = 1'b1; @(negedge clk); k++; flag_clr = 1'b0;
  endtask

  task automatic t_all_zero();
    do_arm(0, 0, 0, 0);
    chk_pulse("R10 low k1", 1, 0);
    chk_pulse("R10 high k2", 2, 1);
    chk_flag("R10 flag not yet", 0);
    chk_pulse("R10 low k3", 3, 0);
    chk_flag("R10 flag", 1);
    chk_pulse("R10 single", 10, 0);
    flag_clr = 1'b1; @(negedge clk); k++; flag_clr = 1'b0;
  endtask

  task automatic t_enable_hold();
    do_arm(5, 4, 5, 3);
    en = 1'b0;
    repeat (4) @(negedge clk);
    chk(timer_val == 3, "R2 hold while disabled", timer_val, 3);
    chk(pulse_out == 1'b0, "R2 no match while disabled", pulse_out, 0);
    en = 1'b1;
    @(negedge clk);
    chk(timer_val == 4, "R2 resume", timer_val, 4);
    @(negedge clk);
    chk(pulse_out == 1'b1, "R4 rise after resume", pulse_out, 1);
    @(negedge clk);
    @(negedge clk);
    chk(pulse_out == 1'b0, "R5 fall after resume", pulse_out, 0);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_flag_race();
    t_wrap_fall();
    t_fall_out_of_range();
    t_rise_out_of_range();
    t_zero_rise();
    t_all_zero();
    t_enable_hold();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule